// File: doc/BRIEF.md
# Mask-Aware Test Energy Estimator

This block sits beside a self-test pattern source whose pseudo-random vectors can be partly overridden by one of several stored masks. Each time a vector is applied, the source pulses a strobe and reports which mask is active; index zero stands for plain pseudo-random vectors. The block keeps a running estimate of the energy of the session in switching-activity units. It does not observe any toggles. Instead it applies a compact cost model. Every vector is charged the per-vector slope of the active mask index. Every time a mask is turned on or off, the switching cost of that mask is charged as well.

Both coefficient tables are written through a simple write port. From the same charges the block also derives a power picture. It captures the largest single-vector charge seen so far. It raises a sticky flag when any single-vector charge goes above a programmed limit. Per-index vector counts and per-mask switch counts are exported, so a test controller can compare the estimate against its own plan. A start pulse opens a new session.

Top module: `test_energy_estimator`

## Requirements
- R1: After reset, and after a start pulse with no strobe in the same cycle, the total, the peak charge, the over-limit flag and all counters read zero, and the previously active mask is taken as index 0.
- R2: On each cycle with `vec_valid` high, the slope coefficient of the active index (`vec_mask`; 0 means no mask) is added to `energy_total`. The new value is visible after the clock edge that samples the strobe.
- R3: A `vec_mask` value above `NUM_MASKS` is treated exactly as index 0.
- R4: When the active index differs from the one of the previous strobe, the same update also adds the switching cost of the old index when the old index is nonzero, and the switching cost of the new index when the new index is nonzero. An unchanged index adds no switching cost, and the switching cost stored at index 0 is never charged.
- R5: `vec_count` holds one CNT_W-bit counter per index, with index i at bits [i*CNT_W +: CNT_W], counting its strobes. `switch_count` holds one counter per mask, with mask i at bits [(i-1)*CNT_W +: CNT_W], counting each turn-on and each turn-off of that mask.
- R6: `energy_total` and every counter saturate at all ones instead of wrapping.
- R7: `peak_cost` holds the largest per-vector charge (slope plus any switching costs) applied since the last reset or start.
- R8: `over_limit` is set when a per-vector charge is strictly greater than `pwr_limit`, and stays set until reset or start. A charge equal to the limit does not set it.
- R9: With `cfg_we` high, `cfg_data` is written to the slope table (`cfg_kind`=0) or the switching-cost table (`cfg_kind`=1) at `cfg_idx`. A strobe in the same cycle uses the value held before the write. A write to an index above `NUM_MASKS` changes nothing.
- R10: A start pulse that coincides with a strobe clears the session and counts that strobe as the first of the new session, with the previous index taken as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Opens a new estimation session |
| cfg_we | input | 1 | Coefficient write enable |
| cfg_kind | input | 1 | 0 selects the slope table, 1 selects the switching-cost table |
| cfg_idx | input | MIDX_W | Table index to write |
| cfg_data | input | COEF_W | Unsigned coefficient value |
| pwr_limit | input | INC_W | Per-vector charge limit for the flag |
| vec_valid | input | 1 | One vector applied this cycle |
| vec_mask | input | MIDX_W | Active mask index, 0 meaning none |
| energy_total | output | ACC_W | Saturating energy estimate |
| vec_count | output | (NUM_MASKS+1)*CNT_W | Strobes per index |
| switch_count | output | NUM_MASKS*CNT_W | On and off events per mask |
| peak_cost | output | INC_W | Largest per-vector charge |
| over_limit | output | 1 | Sticky limit-exceeded flag |

## Verification
Two pairs of functions can meet in one cycle. The first pair is a session start and a vector strobe. The second pair is a coefficient write and a strobe that reads the same table entry. The bench provokes the first by raising start together with a strobe while a different mask is still held. The expected result is a total of exactly that strobe's slope plus its turn-on cost, with only that index counted. The bench provokes the second by rewriting a slope while strobing its index: the old value must be charged, and the new value must be charged on the next strobe.

// File: rtl/tee_pkg.sv
`timescale 1ns/1ps
package tee_pkg;
  typedef enum logic {
    KIND_SLOPE  = 1'b0,
    KIND_SWITCH = 1'b1
  } coef_kind_e;
endpackage

// File: rtl/tee_coef_table.sv
`timescale 1ns/1ps
module tee_coef_table #(
  parameter int NUM_MASKS = 4,
  parameter int COEF_W    = 10,
  parameter int MIDX_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              kind,
  input  logic [MIDX_W-1:0] idx,
  input  logic [COEF_W-1:0] data,
  input  logic [MIDX_W-1:0] rd_cur,
  input  logic [MIDX_W-1:0] rd_prev,
  output logic [COEF_W-1:0] slope_cur,
  output logic [COEF_W-1:0] sw_cur,
  output logic [COEF_W-1:0] sw_prev
);
  import tee_pkg::*;
  localparam int ENTRIES = NUM_MASKS + 1;

  logic [COEF_W-1:0] slope_q [ENTRIES];
  logic [COEF_W-1:0] swc_q   [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    wire hit = we && (idx == MIDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slope_q[i] <= '0;
        swc_q[i]   <= '0;
      end else if (hit) begin
        if (coef_kind_e'(kind) == KIND_SLOPE) slope_q[i] <= data;
        else                                  swc_q[i]   <= data;
      end
    end
  end

  assign slope_cur = slope_q[rd_cur];
  assign sw_cur    = swc_q[rd_cur];
  assign sw_prev   = swc_q[rd_prev];
endmodule

// File: rtl/tee_cost.sv
`timescale 1ns/1ps
module tee_cost #(
  parameter int COEF_W = 10,
  parameter int INC_W  = 12,
  parameter int MIDX_W = 3
) (
  input  logic              valid,
  input  logic [MIDX_W-1:0] cur,
  input  logic [MIDX_W-1:0] prev,
  input  logic [COEF_W-1:0] slope_cur,
  input  logic [COEF_W-1:0] sw_cur,
  input  logic [COEF_W-1:0] sw_prev,
  output logic [INC_W-1:0]  inc,
  output logic              sw_on,
  output logic              sw_off
);
  function automatic logic [INC_W-1:0] vec_cost(
    input logic [COEF_W-1:0] slope,
    input logic [COEF_W-1:0] off_cost,
    input logic [COEF_W-1:0] on_cost,
    input logic              off_ev,
    input logic              on_ev
  );
    logic [INC_W-1:0] s;
    s = INC_W'(slope);
    if (off_ev) s = s + INC_W'(off_cost);
    if (on_ev)  s = s + INC_W'(on_cost);
    return s;
  endfunction

  wire changed = valid && (cur != prev);
  assign sw_on  = changed && (cur  != '0);
  assign sw_off = changed && (prev != '0);
  assign inc    = valid ? vec_cost(slope_cur, sw_prev, sw_cur, sw_off, sw_on) : '0;
endmodule

// File: rtl/tee_accum.sv
`timescale 1ns/1ps
module tee_accum #(
  parameter int ACC_W = 24,
  parameter int INC_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             valid,
  input  logic [INC_W-1:0] inc,
  input  logic [INC_W-1:0] limit,
  output logic [ACC_W-1:0] total,
  output logic [INC_W-1:0] peak,
  output logic             over
);
  function automatic logic [ACC_W-1:0] sat_add(
    input logic [ACC_W-1:0] a,
    input logic [INC_W-1:0] b
  );
    logic [ACC_W:0] s;
    s = {1'b0, a} + (ACC_W+1)'(b);
    return s[ACC_W] ? '1 : s[ACC_W-1:0];
  endfunction

  logic [ACC_W-1:0] base_total, total_d;
  logic [INC_W-1:0] base_peak, peak_d;
  logic             base_over, over_d;
  wire              over_ev = valid && (inc > limit);

  always_comb begin
    base_total = start ? '0 : total;
    base_peak  = start ? '0 : peak;
    base_over  = start ? 1'b0 : over;
    total_d    = valid ? sat_add(base_total, inc) : base_total;
    peak_d     = (valid && inc > base_peak) ? inc : base_peak;
    over_d     = base_over | over_ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      total <= '0;
      peak  <= '0;
      over  <= 1'b0;
    end else begin
      total <= total_d;
      peak  <= peak_d;
      over  <= over_d;
    end
  end

  assert_total_monotonic_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> total >= $past(total));
  assert_over_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (over && !start) |=> over);
  assert_peak_covers_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !start) |=> peak >= $past(inc));
  assert_start_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !valid) |=> (total == '0 && peak == '0 && !over));
endmodule

// File: rtl/tee_counters.sv
`timescale 1ns/1ps
module tee_counters #(
  parameter int NUM_MASKS = 4,
  parameter int CNT_W     = 16,
  parameter int MIDX_W    = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  input  logic                           valid,
  input  logic [MIDX_W-1:0]              cur,
  input  logic [MIDX_W-1:0]              prev,
  input  logic                           sw_on,
  input  logic                           sw_off,
  output logic [(NUM_MASKS+1)*CNT_W-1:0] vec_count,
  output logic [NUM_MASKS*CNT_W-1:0]     switch_count
);
  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] c);
    return (&c) ? c : c + 1'b1;
  endfunction

  for (genvar i = 0; i <= NUM_MASKS; i++) begin : g_vec
    logic [CNT_W-1:0] cnt_q;
    wire hit = valid && (cur == MIDX_W'(i));
    wire [CNT_W-1:0] base = start ? '0 : cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= hit ? sat_inc(base) : base;
    end
    assign vec_count[i*CNT_W +: CNT_W] = cnt_q;
  end

  for (genvar i = 1; i <= NUM_MASKS; i++) begin : g_sw
    logic [CNT_W-1:0] cnt_q;
    wire ev = (sw_on && cur == MIDX_W'(i)) || (sw_off && prev == MIDX_W'(i));
    wire [CNT_W-1:0] base = start ? '0 : cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= ev ? sat_inc(base) : base;
    end
    assign switch_count[(i-1)*CNT_W +: CNT_W] = cnt_q;
  end

  assert_idle_counts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid && !start) |=> ($stable(vec_count) && $stable(switch_count)));
  assert_no_switch_charge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !start && cur == prev) |=> $stable(switch_count));
endmodule

// File: rtl/test_energy_estimator.sv
`timescale 1ns/1ps
module test_energy_estimator #(
  parameter int NUM_MASKS = 4,
  parameter int COEF_W    = 10,
  parameter int ACC_W     = 24,
  parameter int CNT_W     = 16,
  localparam int MIDX_W   = $clog2(NUM_MASKS + 1),
  localparam int INC_W    = COEF_W + 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  input  logic                           cfg_we,
  input  logic                           cfg_kind,
  input  logic [MIDX_W-1:0]              cfg_idx,
  input  logic [COEF_W-1:0]              cfg_data,
  input  logic [INC_W-1:0]               pwr_limit,
  input  logic                           vec_valid,
  input  logic [MIDX_W-1:0]              vec_mask,
  output logic [ACC_W-1:0]               energy_total,
  output logic [(NUM_MASKS+1)*CNT_W-1:0] vec_count,
  output logic [NUM_MASKS*CNT_W-1:0]     switch_count,
  output logic [INC_W-1:0]               peak_cost,
  output logic                           over_limit
);
  localparam logic [MIDX_W-1:0] LAST_IDX = MIDX_W'(NUM_MASKS);

  logic [MIDX_W-1:0] prev_q, prev_eff, cur_m;
  logic [COEF_W-1:0] slope_cur, sw_cur, sw_prev;
  logic [INC_W-1:0]  vec_inc;
  logic              sw_on, sw_off;

  assign cur_m    = (vec_mask > LAST_IDX) ? '0 : vec_mask;
  assign prev_eff = start ? '0 : prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         prev_q <= '0;
    else if (vec_valid) prev_q <= cur_m;
    else if (start)     prev_q <= '0;
  end

  tee_coef_table #(.NUM_MASKS(NUM_MASKS), .COEF_W(COEF_W), .MIDX_W(MIDX_W)) u_table (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .kind(cfg_kind), .idx(cfg_idx),
    .data(cfg_data), .rd_cur(cur_m), .rd_prev(prev_eff),
    .slope_cur(slope_cur), .sw_cur(sw_cur), .sw_prev(sw_prev));

  tee_cost #(.COEF_W(COEF_W), .INC_W(INC_W), .MIDX_W(MIDX_W)) u_cost (
    .valid(vec_valid), .cur(cur_m), .prev(prev_eff), .slope_cur(slope_cur),
    .sw_cur(sw_cur), .sw_prev(sw_prev), .inc(vec_inc), .sw_on(sw_on), .sw_off(sw_off));

  tee_accum #(.ACC_W(ACC_W), .INC_W(INC_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .start(start), .valid(vec_valid), .inc(vec_inc),
    .limit(pwr_limit), .total(energy_total), .peak(peak_cost), .over(over_limit));

  tee_counters #(.NUM_MASKS(NUM_MASKS), .CNT_W(CNT_W), .MIDX_W(MIDX_W)) u_counters (
    .clk(clk), .rst_n(rst_n), .start(start), .valid(vec_valid), .cur(cur_m),
    .prev(prev_eff), .sw_on(sw_on), .sw_off(sw_off),
    .vec_count(vec_count), .switch_count(switch_count));

  assert_prev_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> prev_q == $past(cur_m));
  assert_out_of_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_mask > LAST_IDX) |=> prev_q == '0);
endmodule

// File: tb/test_energy_estimator_tb.sv
`timescale 1ns/1ps
module test_energy_estimator_tb;
  localparam int NM = 4, CW = 10, AW = 16, KW = 8, IW = CW + 2, MW = 3;
  localparam longint ACC_MAX = 65535, CNT_MAX = 255;

  logic clk = 0, rst_n = 0;
  logic start = 0, cfg_we = 0, cfg_kind = 0, vec_valid = 0;
  logic [MW-1:0] cfg_idx = '0, vec_mask = '0;
  logic [CW-1:0] cfg_data = '0;
  logic [IW-1:0] pwr_limit = '0;
  logic [AW-1:0] energy_total;
  logic [(NM+1)*KW-1:0] vec_count;
  logic [NM*KW-1:0] switch_count;
  logic [IW-1:0] peak_cost;
  logic over_limit;

  always #5 clk = ~clk;

  test_energy_estimator #(.NUM_MASKS(NM), .COEF_W(CW), .ACC_W(AW), .CNT_W(KW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_idx(cfg_idx), .cfg_data(cfg_data), .pwr_limit(pwr_limit),
    .vec_valid(vec_valid), .vec_mask(vec_mask), .energy_total(energy_total),
    .vec_count(vec_count), .switch_count(switch_count), .peak_cost(peak_cost),
    .over_limit(over_limit));

  typedef struct {
    longint acc; longint peak; bit flag;
    logic [(NM+1)*KW-1:0] vc; logic [NM*KW-1:0] sw; string tag;
  } exp_t;
  exp_t q[$];

  int checks = 0, fails = 0;
  bit done = 0;
  longint m_acc = 0, m_peak = 0, lim = 4095;
  bit m_flag = 0;
  int m_prev = 0;
  longint m_vc[NM+1], m_sw[NM+1], m_slope[NM+1], m_swc[NM+1];

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(bit v, int m, bit st, bit we, bit kind, int idx, int data, string tag);
    exp_t e;
    longint inc;
    int mm;
    @(negedge clk);
    vec_valid = v; vec_mask = MW'(m); start = st; cfg_we = we; cfg_kind = kind;
    cfg_idx = MW'(idx); cfg_data = CW'(data); pwr_limit = IW'(lim);
    if (st) begin
      m_acc = 0; m_peak = 0; m_flag = 0; m_prev = 0;
      for (int i = 0; i <= NM; i++) begin m_vc[i] = 0; m_sw[i] = 0; end
    end
    if (v) begin
      mm = (m > NM) ? 0 : m;
      inc = m_slope[mm];
      if (mm != m_prev) begin
        if (m_prev != 0) begin
          inc += m_swc[m_prev];
          if (m_sw[m_prev] < CNT_MAX) m_sw[m_prev]++;
        end
        if (mm != 0) begin
          inc += m_swc[mm];
          if (m_sw[mm] < CNT_MAX) m_sw[mm]++;
        end
      end
      if (m_vc[mm] < CNT_MAX) m_vc[mm]++;
      m_acc = (m_acc + inc > ACC_MAX) ? ACC_MAX : m_acc + inc;
      if (inc > m_peak) m_peak = inc;
      if (inc > lim) m_flag = 1;
      m_prev = mm;
    end
    if (we && idx <= NM) begin
      if (kind) m_swc[idx] = data; else m_slope[idx] = data;
    end
    e.acc = m_acc; e.peak = m_peak; e.flag = m_flag; e.tag = tag;
    for (int i = 0; i <= NM; i++) e.vc[i*KW +: KW] = KW'(m_vc[i]);
    for (int i = 1; i <= NM; i++) e.sw[(i-1)*KW +: KW] = KW'(m_sw[i]);
    q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        chk(e.tag, "energy_total", longint'(energy_total), e.acc);
        chk(e.tag, "peak_cost", longint'(peak_cost), e.peak);
        chk(e.tag, "over_limit", longint'(over_limit), longint'(e.flag));
        chk(e.tag, "vec_count", longint'(vec_count), longint'(e.vc));
        chk(e.tag, "switch_count", longint'(switch_count), longint'(e.sw));
      end
    end
  end

  initial begin : driver
    for (int i = 0; i <= NM; i++) begin
      m_vc[i] = 0; m_sw[i] = 0; m_slope[i] = 0; m_swc[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    step(0, 0, 0, 0, 0, 0, 0, "R1");
    // table load; index-0 switch cost must never be charged (R4)
    step(0, 0, 0, 1, 0, 0, 5, "R9");
    step(0, 0, 0, 1, 0, 1, 20, "R9");
    step(0, 0, 0, 1, 0, 2, 30, "R9");
    step(0, 0, 0, 1, 0, 3, 7, "R9");
    step(0, 0, 0, 1, 0, 4, 1000, "R9");
    step(0, 0, 0, 1, 1, 0, 999, "R4");
    step(0, 0, 0, 1, 1, 1, 100, "R9");
    step(0, 0, 0, 1, 1, 2, 50, "R9");
    step(0, 0, 0, 1, 1, 3, 3, "R9");
    step(0, 0, 0, 1, 1, 4, 1000, "R9");
    step(0, 0, 0, 1, 0, 5, 500, "R9");
    lim = 1500;
    step(1, 0, 0, 0, 0, 0, 0, "R2");
    step(1, 0, 0, 0, 0, 0, 0, "R2");
    step(1, 1, 0, 0, 0, 0, 0, "R4");
    step(1, 1, 0, 0, 0, 0, 0, "R4");
    step(1, 2, 0, 0, 0, 0, 0, "R4");
    step(1, 0, 0, 0, 0, 0, 0, "R4");
    step(1, 5, 0, 0, 0, 0, 0, "R3");
    step(1, 7, 0, 0, 0, 0, 0, "R3");
    step(1, 4, 0, 0, 0, 0, 0, "R8");
    step(1, 4, 0, 0, 0, 0, 0, "R7");
    step(1, 0, 0, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 0, 0, 0, 0, "R5");
    step(0, 0, 1, 0, 0, 0, 0, "R1");
    lim = 2000;
    step(1, 4, 0, 0, 0, 0, 0, "R8");
    lim = 1999;
    step(1, 0, 0, 0, 0, 0, 0, "R8");
    step(1, 4, 0, 0, 0, 0, 0, "R8");
    step(1, 3, 0, 1, 0, 3, 60, "R9");
    step(1, 3, 0, 0, 0, 0, 0, "R9");
    step(1, 1, 1, 0, 0, 0, 0, "R10");
    step(1, 2, 0, 0, 0, 0, 0, "R10");
    for (int k = 0; k < 300; k++) step(1, 4, 0, 0, 0, 0, 0, "R6");
    step(0, 0, 0, 0, 0, 0, 0, "R6");
    repeat (3) @(posedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule